// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller with Pipelined Read

This block is the clocked front end of a pipelined burst static RAM, with a small behavioural word array behind it. On every rising clock edge it samples two active-low address strobes, one for a processor and one for a controller. It also samples an advance input, three chip enables, a global write enable, a byte write enable and one write select per byte.

A strobe loads an external address and latches the device's select state. The two low address bits then run a 2-bit linear burst counter, and the upper bits stay fixed. Writes are either full-word or byte-masked. Reads are registered, so data appears one clock after the access edge. An asynchronous output enable gates the drive of the data bus, which is exposed as a data value plus a drive-enable for the pad.

The processor strobe has priority over the controller strobe and is acted on only while the first chip enable is low. A cycle started by the processor strobe is always a read. The first read after the device was deselected keeps the bus undriven for one clock, whatever the output enable shows.

Top module: `sync_burst_sram`

## Requirements
- R1: A load happens on an edge where `adsc_n` is low, or where `adsp_n` and `ce1_n` are both low. If `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on that edge, the device becomes selected and the word at `addr` is accessed.
- R2: When `adsp_n` and `ce1_n` are both low, the processor load is taken even if `adsc_n` is also low, and the cycle is a read whatever the write enables show. With `ce1_n` high, a low `adsp_n` is ignored: it loads nothing and the current access continues.
- R3: The chip enables are sampled only on a load edge. The select state they produce is kept on every other edge.
- R4: On a selected edge with no load and `adv_n` low, the accessed address is the previous one with its two low bits incremented modulo 4, so the order is linear and wraps 3 to 0. The upper bits stay unchanged. With `adv_n` high, the same word is accessed again.
- R5: On a selected edge that is not a processor load, `gw_n`=0 writes all bytes of `din` to the accessed word, whatever `bwe_n` and `bw_n` show.
- R6: Otherwise, with `bwe_n`=0, byte i (`din` bits 8i+7..8i) is written exactly when `bw_n[i]`=0. When no byte is selected for writing, the selected edge is a read.
- R7: A read on edge k places the accessed word on `dq_o` after edge k. `dq_o` then holds that value until the next read.
- R8: `dq_oe` is high only while `oe_n` is low and the last edge was a selected read. After a write edge or a deselected edge, `dq_oe` is low.
- R9: If the device was deselected before a read edge, `dq_oe` stays low for the clock that follows that edge, even with `oe_n` low.
- R10: After reset the device is deselected, `dq_oe` is 0, `dq_o` is 0 and every memory word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | External word address |
| din | input | 8*NB | Write data, sampled on the access edge |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | First chip enable, active low |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| gw_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | NB | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_o | output | 8*NB | Registered read data |
| dq_oe | output | 1 | Bus drive enable for the tri-state pad |

## Verification
A wrong select state shows up at the ports in the clock after the faulty edge. The bus is driven when it should float, or a write is lost, and the lost write surfaces at the next read of that word. A counter that steps wrongly or fails to wrap returns the wrong word one clock after the advance edge. A missing first-read mask shows as `dq_oe` rising one clock too early after a deselect. Random strobe and enable mixes, compared every cycle against a bench model, expose each of these within a few cycles.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [NB*8-1:0] din,
  input  logic            adsp_n,
  input  logic            adsc_n,
  input  logic            adv_n,
  input  logic            ce1_n,
  input  logic            ce2,
  input  logic            ce3_n,
  input  logic            gw_n,
  input  logic            bwe_n,
  input  logic [NB-1:0]   bw_n,
  input  logic            oe_n,
  output logic [NB*8-1:0] dq_o,
  output logic            dq_oe
);
  localparam int DW = NB * 8;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-3:0] base_q;
  logic [1:0]    cnt_q;
  logic          sel_q, rd_vld, mask_q;
  logic [DW-1:0] rdata_q;
  logic [NB-1:0] wmask;

  wire p_ld = !adsp_n && !ce1_n;
  wire c_ld = !adsc_n && !p_ld;
  wire ld   = p_ld || c_ld;

  wire            sel_n  = ld ? (!ce1_n && ce2 && !ce3_n) : sel_q;
  wire [1:0]      cnt_n  = ld ? addr[1:0] : ((sel_q && !adv_n) ? cnt_q + 2'd1 : cnt_q);
  wire [AW-3:0]   base_n = ld ? addr[AW-1:2] : base_q;
  wire [AW-1:0]   acc    = {base_n, cnt_n};

  always_comb
    for (int i = 0; i < NB; i++)
      wmask[i] = !p_ld && (!gw_n || (!bwe_n && !bw_n[i]));

  wire do_wr = sel_n && (|wmask);
  wire do_rd = sel_n && !(|wmask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q   <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      rd_vld  <= 1'b0;
      mask_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      sel_q  <= sel_n;
      base_q <= base_n;
      cnt_q  <= cnt_n;
      rd_vld <= do_rd;
      mask_q <= do_rd && !sel_q;
      if (do_rd) rdata_q <= mem[acc];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (do_wr) begin
      for (int i = 0; i < NB; i++)
        if (wmask[i]) mem[acc][i*8 +: 8] <= din[i*8 +: 8];
    end

  assign dq_o  = rdata_q;
  assign dq_oe = !oe_n && rd_vld && !mask_q;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       adsp_n,
  input logic       adsc_n,
  input logic       adv_n,
  input logic       ce1_n,
  input logic       ce2,
  input logic       ce3_n,
  input logic       sel_q,
  input logic       rd_vld,
  input logic [1:0] cnt_q,
  input logic       dq_oe
);
  AST_CE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (adsc_n && (adsp_n || ce1_n)) |=> $stable(sel_q)); // R3

  AST_PROC_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce1_n && ce2 && !ce3_n) |=> rd_vld); // R2

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && adsc_n && (adsp_n || ce1_n) && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R4

  AST_FIRST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && !$past(sel_q)) |-> !dq_oe); // R9

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> !dq_oe); // R8

  AST_READ_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> sel_q); // R7
endmodule

bind sync_burst_sram sync_burst_sram_chk u_chk (.*);

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  addr = 0;
  logic [31:0] din = 0;
  logic        adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n;
  logic [3:0]  bw_n;
  logic [31:0] dq_o;
  logic        dq_oe;
  int          total = 0, fails = 0;

  logic [31:0] m_mem [64];
  logic [31:0] m_rd;
  logic [5:0]  m_ad;
  bit          m_sel, m_rv, m_mask;

  sync_burst_sram dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0;
  endtask

  task automatic model_step();
    bit pl, cl, ld, ns, osel;
    logic [5:0] ea;
    logic [3:0] wm;
    pl = !adsp_n && !ce1_n;
    cl = !adsc_n && !pl;
    ld = pl || cl;
    osel = m_sel;
    ns = ld ? (!ce1_n && ce2 && !ce3_n) : m_sel;
    if (ld) ea = addr;
    else if (m_sel && !adv_n) ea = {m_ad[5:2], m_ad[1:0] + 2'd1};
    else ea = m_ad;
    for (int b = 0; b < 4; b++) wm[b] = !pl && (!gw_n || (!bwe_n && !bw_n[b]));
    m_sel = ns;
    m_ad = ea;
    if (ns && wm != 0) begin
      for (int b = 0; b < 4; b++) if (wm[b]) m_mem[ea][b*8 +: 8] = din[b*8 +: 8];
      m_rv = 0; m_mask = 0;
    end else if (ns) begin
      m_rd = m_mem[ea]; m_rv = 1; m_mask = !osel;
    end else begin
      m_rv = 0; m_mask = 0;
    end
  endtask

  function automatic logic exp_oe();
    return !oe_n && m_rv && !m_mask;
  endfunction

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, "dq_oe", {31'd0, dq_oe}, {31'd0, exp_oe()});
    chk(tag, "dq_o", dq_o, m_rd);
  endtask

  initial begin
    #(20 * 150000);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle();
    for (int w = 0; w < 64; w++) m_mem[w] = 0;
    m_rd = 0; m_ad = 0; m_sel = 0; m_rv = 0; m_mask = 0;
    repeat (2) @(negedge clk);
    chk("R10", "dq_oe", {31'd0, dq_oe}, 32'd0);
    chk("R10", "dq_o", dq_o, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R5 global write, then read back with no mask (previously selected)
    adsc_n = 0; addr = 8; gw_n = 0; bwe_n = 0; bw_n = 4'hF; din = 32'hCAFE_0008;
    tick("R5"); idle();
    adsc_n = 0; addr = 8;
    tick("R1");
    chk("R7", "read data", dq_o, 32'hCAFE_0008);
    idle();

    // R10 untouched word reads zero
    adsc_n = 0; addr = 33;
    tick("R10");
    chk("R10", "zero word", dq_o, 32'd0);
    idle();

    // R6 byte write through selects
    adsc_n = 0; addr = 9; gw_n = 0; din = 32'h1111_1111;
    tick("R5"); idle();
    adsc_n = 0; addr = 9; bwe_n = 0; bw_n = 4'b1010; din = 32'hAABB_CCDD;
    tick("R6"); idle();
    adsc_n = 0; addr = 9; bwe_n = 1; bw_n = 4'b0000; din = 32'hFFFF_FFFF;
    tick("R6");
    chk("R6", "masked bytes", dq_o, 32'h11BB_11DD);
    idle();

    // R2 both strobes with writes: processor read wins
    adsp_n = 0; adsc_n = 0; addr = 9; gw_n = 0; din = 32'h0;
    tick("R2");
    chk("R2", "no write", dq_o, 32'h11BB_11DD);
    idle();
    adsp_n = 0; ce1_n = 1; addr = 40;
    tick("R2");
    chk("R2", "ignored strobe", dq_o, 32'h11BB_11DD);
    idle();

    // R9 mask after deselect
    adsc_n = 0; ce2 = 0; addr = 8;
    tick("R8"); idle();
    adsc_n = 0; addr = 8;
    tick("R9");
    chk("R9", "masked oe", {31'd0, dq_oe}, 32'd0);
    idle();
    tick("R9");
    chk("R9", "unmasked", {31'd0, dq_oe}, 32'd1);

    // R3 enables ignored without load
    ce1_n = 1; ce2 = 0; ce3_n = 1;
    tick("R3");
    chk("R3", "still driven", {31'd0, dq_oe}, 32'd1);
    idle();

    // R4 burst wrap: fill 12..15 then read from 14
    for (int k = 12; k < 16; k++) begin
      adsc_n = 0; addr = 6'(k); gw_n = 0; din = 32'hB000_0000 + k;
      tick("R5"); idle();
    end
    adsc_n = 0; addr = 14;
    tick("R4"); idle();
    chk("R4", "start", dq_o, 32'hB000_000E);
    adv_n = 0;
    tick("R4"); chk("R4", "step 15", dq_o, 32'hB000_000F);
    tick("R4"); chk("R4", "wrap 12", dq_o, 32'hB000_000C);
    tick("R4"); chk("R4", "step 13", dq_o, 32'hB000_000D);
    adv_n = 1;
    tick("R4"); chk("R4", "hold 13", dq_o, 32'hB000_000D);

    // R8 oe high and write cycle stop drive
    oe_n = 1;
    tick("R8");
    chk("R8", "oe high", {31'd0, dq_oe}, 32'd0);
    oe_n = 0; adsc_n = 0; addr = 20; gw_n = 0; din = 32'h2020_2020;
    tick("R8");
    chk("R8", "write", {31'd0, dq_oe}, 32'd0);
    idle();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      adsp_n = ($urandom % 100) >= 15;
      adsc_n = ($urandom % 100) >= 25;
      adv_n  = ($urandom % 2) == 0;
      ce1_n  = ($urandom % 100) < 12;
      ce2    = ($urandom % 100) >= 12;
      ce3_n  = ($urandom % 100) < 12;
      gw_n   = ($urandom % 100) >= 10;
      bwe_n  = ($urandom % 100) >= 30;
      bw_n   = 4'($urandom);
      oe_n   = ($urandom % 100) < 20;
      addr   = 6'($urandom);
      din    = $urandom;
      tick("rnd");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule